// File: doc/BRIEF.md
# Unary Multiply-Divide Group Sequencer

This block executes one operation from a group of single-operand arithmetic instructions selected by a 3-bit code. The group covers a flags-only test of the operand against an immediate, bitwise inversion, two's-complement negation, unsigned and signed multiply, and unsigned and signed divide. Every operation runs on either byte or word operands. Multiply and divide work on an accumulator that is twice the operand width. The surrounding execution unit supplies the operand, the immediate and the accumulator. It then acts on the write strobes and the data that come back with the one-cycle `done` pulse.

A start pulse is accepted only while the block is idle. It captures all inputs and loads a down-counter with the wait count of the selected operation. The result is produced once that count runs out, so each operation shows a fixed, size-dependent latency. The byte width is a parameter; the word is twice the byte and the accumulator twice the word.

Top module: `mulDivGroup`

## Requirements
- R1: A `start` high at a rising edge while `busy` is low captures `regSel`, `isWord`, `operand`, `immed` and `accIn`, and raises `busy`. `done` is high for exactly one cycle per accepted start. A `start` seen while `busy` is high is ignored: it gives no extra `done` and does not alter the running operation.
- R2: With the start captured at edge k, `done` is high after edge k+L+1, where the wait L is 0 for codes 0 and 1 and 2 for codes 2 to 5. Code 6 waits 15 (byte) or 23 (word) and code 7 waits 17 (byte) or 24 (word). `isWord`=1 selects word size.
- R3: Code 0 (test) forms operand AND immediate at the operand size. It pulses `flagUpdate` with zero and sign taken from that value and carry and overflow cleared. It pulses neither write strobe.
- R4: Code 1 is undefined: it pulses `illegalOp` with `done` and pulses no write strobe and no `flagUpdate`.
- R5: Code 2 (not) pulses `writeOperand` with the inverted operand. For byte size, `operandOut[15:8]` keeps `operand[15:8]`. There is no flag update.
- R6: Code 3 (negate) writes the two's complement of the operand the same way as R5. Its flags are carry = operand nonzero, overflow = operand equal to the most negative value, and zero and sign from the result.
- R7: Code 4 (unsigned multiply) pulses `writeAcc`. For byte size, `accOut[15:0]` = `accIn[7:0]`×`operand[7:0]` and `accOut[31:16]` = `accIn[31:16]`. For word size, `accOut` = `accIn[15:0]`×`operand`. Carry and overflow are set when the upper half of the product is nonzero, and zero and sign come from the double-width product.
- R8: Code 5 (signed multiply) works like R7 on two's-complement values. Carry and overflow are set when the upper half is not the sign extension of the lower half.
- R9: Code 6 (unsigned divide) divides the double-width accumulator (`accIn[15:0]` for byte, `accIn[31:0]` for word) by the operand. It writes the quotient to the low half and the remainder to the high half of that region. For byte size, `accIn[31:16]` is preserved. There is no flag update.
- R10: Code 7 (signed divide) writes as in R9. The quotient is truncated toward zero and the remainder takes the sign of the dividend.
- R11: For codes 6 and 7, a zero divisor or a quotient that does not fit the operand size pulses `divError` with `done` and suppresses `writeAcc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| regSel | input | 3 | Operation code 0..7 |
| isWord | input | 1 | 1 = word size, 0 = byte size |
| operand | input | 16 | Source operand / divisor |
| immed | input | 16 | Immediate for the test operation |
| accIn | input | 32 | Accumulator (single or double width used) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| writeOperand | output | 1 | Write `operandOut` back (with done) |
| writeAcc | output | 1 | Write `accOut` back (with done) |
| flagUpdate | output | 1 | Flags are valid and should be updated (with done) |
| illegalOp | output | 1 | Undefined code executed (with done) |
| divError | output | 1 | Divide by zero or quotient overflow (with done) |
| operandOut | output | 16 | Result for the operand |
| accOut | output | 32 | Result for the accumulator |
| flagCarry | output | 1 | Carry flag |
| flagOverflow | output | 1 | Overflow flag |
| flagZero | output | 1 | Zero flag |
| flagSign | output | 1 | Sign flag |

## Verification
The multiply inputs include all-ones byte operands, which make the upper half significant for the unsigned form. Small and mixed-sign values separate the signed sign-extension test from the unsigned nonzero test. The divides are tried with an in-range quotient, a quotient too wide for the size, a zero divisor, and negative dividends with odd results. Together these pin down truncation direction and remainder sign. Negation is tried on zero, on the most negative byte and on a small word, which tells the carry rule apart from the overflow rule. A start pulse is also injected during a long divide, to show that it neither shortens the latency nor spawns a second completion.

// File: rtl/muldivPkg.sv
package muldivPkg;
  typedef enum logic [2:0] {
    OP_TEST  = 3'd0,
    OP_UNDEF = 3'd1,
    OP_NOT   = 3'd2,
    OP_NEG   = 3'd3,
    OP_MULU  = 3'd4,
    OP_MULS  = 3'd5,
    OP_DIVU  = 3'd6,
    OP_DIVS  = 3'd7
  } opSel_t;

  typedef struct packed {
    logic load;
    logic finish;
  } ctlStrobe_t;
endpackage

// File: rtl/arithSlice.sv
module arithSlice #(
  parameter int N = 8
) (
  input  logic           isSigned,
  input  logic [N-1:0]   opA,
  input  logic [N-1:0]   imm,
  input  logic [N-1:0]   accLo,
  input  logic [2*N-1:0] dividend,
  output logic [N-1:0]   andRes,
  output logic [N-1:0]   notRes,
  output logic [N-1:0]   negRes,
  output logic [2*N-1:0] mulRes,
  output logic           mulHigh,
  output logic [N-1:0]   divQ,
  output logic [N-1:0]   divR,
  output logic           divErr
);
  localparam int DW = 2 * N;
  localparam int SW = DW + 2;

  logic [DW-1:0]        mulU;
  logic signed [DW-1:0] mulS;
  logic                 opZero;
  logic [DW-1:0]        dvsU, qU, rU;
  logic signed [SW-1:0] sDvd, sDvs, qS, rS;
  logic                 errU, errS;

  assign andRes = opA & imm;
  assign notRes = ~opA;
  assign negRes = N'(0) - opA;

  assign mulU = DW'(accLo) * DW'(opA);
  assign mulS = $signed({{N{accLo[N-1]}}, accLo}) * $signed({{N{opA[N-1]}}, opA});

  assign opZero = (opA == '0);
  assign dvsU   = opZero ? DW'(1) : {{N{1'b0}}, opA};
  assign qU     = dividend / dvsU;
  assign rU     = dividend % dvsU;
  assign errU   = opZero || (|qU[DW-1:N]);

  assign sDvd = $signed({{2{dividend[DW-1]}}, dividend});
  assign sDvs = opZero ? SW'(1) : $signed({{(N+2){opA[N-1]}}, opA});
  assign qS   = sDvd / sDvs;
  assign rS   = sDvd % sDvs;
  // quotient fits when bits SW-1..N-1 are all equal
  assign errS = opZero || !((&qS[SW-1:N-1]) || !(|qS[SW-1:N-1]));

  always_comb begin
    if (isSigned) begin
      mulRes  = mulS;
      mulHigh = (mulS[DW-1:N] != {N{mulS[N-1]}});
      divQ    = qS[N-1:0];
      divR    = rS[N-1:0];
      divErr  = errS;
    end else begin
      mulRes  = mulU;
      mulHigh = |mulU[DW-1:N];
      divQ    = qU[N-1:0];
      divR    = rU[N-1:0];
      divErr  = errU;
    end
  end
endmodule

// File: rtl/mdControl.sv
module mdControl
  import muldivPkg::*;
#(
  parameter int WAIT_SHORT  = 2,
  parameter int WAIT_DIVU_B = 15,
  parameter int WAIT_DIVU_W = 23,
  parameter int WAIT_DIVS_B = 17,
  parameter int WAIT_DIVS_W = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] regSel,
  input  logic       isWord,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int MAXW  = (WAIT_DIVU_W > WAIT_DIVS_W) ? WAIT_DIVU_W : WAIT_DIVS_W;
  localparam int CNT_W = $clog2(MAXW + 1);

  logic             running;
  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] waitSel;

  always_comb begin
    unique case (opSel_t'(regSel))
      OP_TEST, OP_UNDEF: waitSel = '0;
      OP_NOT, OP_NEG, OP_MULU, OP_MULS: waitSel = CNT_W'(WAIT_SHORT);
      OP_DIVU: waitSel = isWord ? CNT_W'(WAIT_DIVU_W) : CNT_W'(WAIT_DIVU_B);
      default: waitSel = isWord ? CNT_W'(WAIT_DIVS_W) : CNT_W'(WAIT_DIVS_B);
    endcase
  end

  assign strobe.load   = start && !running;
  assign strobe.finish = running && (waitCnt == '0);
  assign busy          = running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      waitCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.load) begin
        running <= 1'b1;
        waitCnt <= waitSel;
      end else if (strobe.finish) begin
        running <= 1'b0;
      end else if (running) begin
        waitCnt <= waitCnt - 1'b1;
      end
    end
  end

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r1_busy_on_start: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  a_r1_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.finish) |=> (busy && !done));
endmodule

// File: rtl/mdDatapath.sv
module mdDatapath
  import muldivPkg::*;
#(
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [2:0]       regSel,
  input  logic             isWord,
  input  logic [2*BW-1:0]  operand,
  input  logic [2*BW-1:0]  immed,
  input  logic [4*BW-1:0]  accIn,
  output logic             writeOperand,
  output logic             writeAcc,
  output logic             flagUpdate,
  output logic             illegalOp,
  output logic             divError,
  output logic [2*BW-1:0]  operandOut,
  output logic [4*BW-1:0]  accOut,
  output logic             flagCarry,
  output logic             flagOverflow,
  output logic             flagZero,
  output logic             flagSign
);
  localparam int WW = 2 * BW;
  localparam int AW = 2 * WW;

  opSel_t        selQ;
  logic          wordQ;
  logic [WW-1:0] opQ, immQ;
  logic [AW-1:0] accQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= OP_TEST;
      wordQ <= 1'b0;
      opQ   <= '0;
      immQ  <= '0;
      accQ  <= '0;
    end else if (strobe.load) begin
      selQ  <= opSel_t'(regSel);
      wordQ <= isWord;
      opQ   <= operand;
      immQ  <= immed;
      accQ  <= accIn;
    end
  end

  logic          isSigned;
  logic [BW-1:0] bAnd, bNot, bNeg, bQ, bR;
  logic [WW-1:0] bMul;
  logic          bMulHi, bErr;
  logic [WW-1:0] wAnd, wNot, wNeg, wQ, wR;
  logic [AW-1:0] wMul;
  logic          wMulHi, wErr;

  assign isSigned = selQ[0];

  arithSlice #(.N(BW)) byteSlice (
    .isSigned(isSigned), .opA(opQ[BW-1:0]), .imm(immQ[BW-1:0]),
    .accLo(accQ[BW-1:0]), .dividend(accQ[WW-1:0]),
    .andRes(bAnd), .notRes(bNot), .negRes(bNeg), .mulRes(bMul),
    .mulHigh(bMulHi), .divQ(bQ), .divR(bR), .divErr(bErr)
  );

  arithSlice #(.N(WW)) wordSlice (
    .isSigned(isSigned), .opA(opQ), .imm(immQ),
    .accLo(accQ[WW-1:0]), .dividend(accQ),
    .andRes(wAnd), .notRes(wNot), .negRes(wNeg), .mulRes(wMul),
    .mulHigh(wMulHi), .divQ(wQ), .divR(wR), .divErr(wErr)
  );

  // size-selected views
  logic [WW-1:0] andV, notV, negV;
  logic          andMsb, negMsb, opNonZero, opMin;
  logic [AW-1:0] mulV, divV;
  logic          mulHi, mulZero, mulMsb, divErrV;

  always_comb begin
    if (wordQ) begin
      andV      = wAnd;
      andMsb    = wAnd[WW-1];
      notV      = wNot;
      negV      = wNeg;
      negMsb    = wNeg[WW-1];
      opNonZero = |opQ;
      opMin     = (opQ == {1'b1, {(WW-1){1'b0}}});
      mulV      = wMul;
      mulHi     = wMulHi;
      mulZero   = (wMul == '0);
      mulMsb    = wMul[AW-1];
      divV      = {wR, wQ};
      divErrV   = wErr;
    end else begin
      andV      = {{BW{1'b0}}, bAnd};
      andMsb    = bAnd[BW-1];
      notV      = {opQ[WW-1:BW], bNot};
      negV      = {opQ[WW-1:BW], bNeg};
      negMsb    = bNeg[BW-1];
      opNonZero = |opQ[BW-1:0];
      opMin     = (opQ[BW-1:0] == {1'b1, {(BW-1){1'b0}}});
      mulV      = {accQ[AW-1:WW], bMul};
      mulHi     = bMulHi;
      mulZero   = (bMul == '0);
      mulMsb    = bMul[WW-1];
      divV      = {accQ[AW-1:WW], bR, bQ};
      divErrV   = bErr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      writeOperand <= 1'b0;
      writeAcc     <= 1'b0;
      flagUpdate   <= 1'b0;
      illegalOp    <= 1'b0;
      divError     <= 1'b0;
      operandOut   <= '0;
      accOut       <= '0;
      flagCarry    <= 1'b0;
      flagOverflow <= 1'b0;
      flagZero     <= 1'b0;
      flagSign     <= 1'b0;
    end else begin
      writeOperand <= 1'b0;
      writeAcc     <= 1'b0;
      flagUpdate   <= 1'b0;
      illegalOp    <= 1'b0;
      divError     <= 1'b0;
      if (strobe.finish) begin
        unique case (selQ)
          OP_TEST: begin
            flagUpdate   <= 1'b1;
            flagCarry    <= 1'b0;
            flagOverflow <= 1'b0;
            flagZero     <= (andV == '0);
            flagSign     <= andMsb;
          end
          OP_UNDEF: illegalOp <= 1'b1;
          OP_NOT: begin
            writeOperand <= 1'b1;
            operandOut   <= notV;
          end
          OP_NEG: begin
            writeOperand <= 1'b1;
            operandOut   <= negV;
            flagUpdate   <= 1'b1;
            flagCarry    <= opNonZero;
            flagOverflow <= opMin;
            flagZero     <= !opNonZero;
            flagSign     <= negMsb;
          end
          OP_MULU, OP_MULS: begin
            writeAcc     <= 1'b1;
            accOut       <= mulV;
            flagUpdate   <= 1'b1;
            flagCarry    <= mulHi;
            flagOverflow <= mulHi;
            flagZero     <= mulZero;
            flagSign     <= mulMsb;
          end
          default: begin
            if (divErrV) begin
              divError <= 1'b1;
            end else begin
              writeAcc <= 1'b1;
              accOut   <= divV;
            end
          end
        endcase
      end
    end
  end

  a_r4_undef_nowrite: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (!writeOperand && !writeAcc && !flagUpdate));
  a_r11_err_nowrite: assert property (@(posedge clk) disable iff (!rstN)
    divError |-> !writeAcc);
  a_r3_test_flags: assert property (@(posedge clk) disable iff (!rstN)
    (flagUpdate && selQ == OP_TEST) |-> (!flagCarry && !flagOverflow && !writeOperand));
  a_r7_mul_flags: assert property (@(posedge clk) disable iff (!rstN)
    (flagUpdate && (selQ == OP_MULU || selQ == OP_MULS)) |-> (flagCarry == flagOverflow));
endmodule

// File: rtl/mulDivGroup.sv
module mulDivGroup
  import muldivPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  regSel,
  input  logic        isWord,
  input  logic [15:0] operand,
  input  logic [15:0] immed,
  input  logic [31:0] accIn,
  output logic        busy,
  output logic        done,
  output logic        writeOperand,
  output logic        writeAcc,
  output logic        flagUpdate,
  output logic        illegalOp,
  output logic        divError,
  output logic [15:0] operandOut,
  output logic [31:0] accOut,
  output logic        flagCarry,
  output logic        flagOverflow,
  output logic        flagZero,
  output logic        flagSign
);
  ctlStrobe_t strobe;

  mdControl ctl (
    .clk(clk), .rstN(rstN), .start(start), .regSel(regSel), .isWord(isWord),
    .strobe(strobe), .busy(busy), .done(done)
  );

  mdDatapath #(.BW(8)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regSel(regSel), .isWord(isWord),
    .operand(operand), .immed(immed), .accIn(accIn),
    .writeOperand(writeOperand), .writeAcc(writeAcc), .flagUpdate(flagUpdate),
    .illegalOp(illegalOp), .divError(divError), .operandOut(operandOut),
    .accOut(accOut), .flagCarry(flagCarry), .flagOverflow(flagOverflow),
    .flagZero(flagZero), .flagSign(flagSign)
  );

  a_r1_strobes_with_done: assert property (@(posedge clk) disable iff (!rstN)
    (writeOperand || writeAcc || flagUpdate || illegalOp || divError) |-> done);
endmodule

// File: tb/tb_mulDivGroup.sv
module tb_mulDivGroup;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] regSel = '0;
  logic isWord = 1'b0;
  logic [15:0] operand = '0, immed = '0;
  logic [31:0] accIn = '0;
  logic busy, done, writeOperand, writeAcc, flagUpdate, illegalOp, divError;
  logic [15:0] operandOut;
  logic [31:0] accOut;
  logic flagCarry, flagOverflow, flagZero, flagSign;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mulDivGroup dut (.*);

  typedef struct {
    logic [15:0] opOut;
    logic [31:0] accOut;
    logic wOp, wAcc, fUpd, ill, dErr, c, v, z, s;
    int lat;
    int launch;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int fails = 0;
  int cycleCnt = 0;
  bit finished = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  function automatic longint sx(longint v, int bits);
    return v[bits-1] ? v - (longint'(1) <<< bits) : v;
  endfunction

  function automatic exp_t model(int sel, bit word, logic [15:0] op,
                                 logic [15:0] imm, logic [31:0] acc);
    exp_t e;
    int n = word ? 16 : 8;
    longint mask = (longint'(1) <<< n) - 1;
    longint mask2 = (longint'(1) <<< (2 * n)) - 1;
    longint opv = longint'(op) & mask;
    longint r, p, q, rm, dvd, sd, sv;
    e = '{opOut: 'x, accOut: 'x, wOp: 0, wAcc: 0, fUpd: 0, ill: 0, dErr: 0,
          c: 'x, v: 'x, z: 'x, s: 'x, lat: 1, launch: 0, tag: ""};
    case (sel)
      0: begin
        r = opv & (longint'(imm) & mask);
        e.fUpd = 1; e.c = 0; e.v = 0; e.z = (r == 0); e.s = r[n-1];
        e.tag = "R3";
      end
      1: begin e.ill = 1; e.tag = "R4"; end
      2, 3: begin
        r = (sel == 2) ? (~opv & mask) : ((-opv) & mask);
        e.wOp = 1;
        e.opOut = word ? 16'(r) : {op[15:8], 8'(r)};
        e.lat = 3;
        if (sel == 3) begin
          e.fUpd = 1; e.c = (opv != 0); e.v = (opv == (longint'(1) <<< (n - 1)));
          e.z = (r == 0); e.s = r[n-1]; e.tag = "R6";
        end else e.tag = "R5";
      end
      4, 5: begin
        if (sel == 4) begin
          p = (longint'(acc) & mask) * opv;
          e.c = ((p >>> n) != 0);
        end else begin
          p = sx(longint'(acc) & mask, n) * sx(opv, n);
          e.c = (p < -(longint'(1) <<< (n - 1))) || (p > (longint'(1) <<< (n - 1)) - 1);
        end
        p = p & mask2;
        e.v = e.c; e.z = (p == 0); e.s = p[2*n-1];
        e.wAcc = 1; e.fUpd = 1; e.lat = 3;
        e.accOut = word ? 32'(p) : {acc[31:16], 16'(p)};
        e.tag = (sel == 4) ? "R7" : "R8";
      end
      default: begin
        dvd = longint'(acc) & mask2;
        e.lat = (sel == 6) ? (word ? 24 : 16) : (word ? 25 : 18);
        e.tag = (sel == 6) ? "R9" : "R10";
        if (opv == 0) begin
          e.dErr = 1; e.tag = "R11";
        end else begin
          if (sel == 6) begin
            q = dvd / opv; rm = dvd % opv;
            e.dErr = (q > mask);
          end else begin
            sd = sx(dvd, 2 * n); sv = sx(opv, n);
            q = sd / sv; rm = sd % sv;
            e.dErr = (q < -(longint'(1) <<< (n - 1))) || (q > (longint'(1) <<< (n - 1)) - 1);
          end
          if (e.dErr) e.tag = "R11";
          else begin
            e.wAcc = 1;
            e.accOut = word ? {16'(rm), 16'(q)} : {acc[31:16], 8'(rm), 8'(q)};
          end
        end
      end
    endcase
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic issue(int sel, bit word, logic [15:0] op, logic [15:0] imm,
                       logic [31:0] acc);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    regSel = 3'(sel); isWord = word; operand = op; immed = imm; accIn = acc;
    start = 1'b1;
    e = model(sel, word, op, imm, acc);
    e.launch = cycleCnt + 1;
    expQ.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  // R1: start pulse while busy with different inputs must be ignored
  task automatic pokeWhileBusy();
    @(negedge clk);
    regSel = 3'd1; isWord = 1'b0; operand = 16'h0; accIn = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      exp_t e;
      if (expQ.size() == 0) begin
        check(0, "R1", "unexpected done", 1, 0);
      end else begin
        e = expQ.pop_front();
        check(cycleCnt - e.launch == e.lat, "R2", "latency", cycleCnt - e.launch, e.lat);
        check({writeOperand, writeAcc, flagUpdate, illegalOp, divError} ==
              {e.wOp, e.wAcc, e.fUpd, e.ill, e.dErr}, e.tag, "strobes",
              {writeOperand, writeAcc, flagUpdate, illegalOp, divError},
              {e.wOp, e.wAcc, e.fUpd, e.ill, e.dErr});
        if (e.wOp) check(operandOut == e.opOut, e.tag, "operandOut", operandOut, e.opOut);
        if (e.wAcc) check(accOut == e.accOut, e.tag, "accOut", accOut, e.accOut);
        if (e.fUpd) check({flagCarry, flagOverflow, flagZero, flagSign} == {e.c, e.v, e.z, e.s},
                          e.tag, "flags CVZS", {flagCarry, flagOverflow, flagZero, flagSign},
                          {e.c, e.v, e.z, e.s});
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(0, "R1", "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, writeOperand, writeAcc, flagUpdate, illegalOp, divError} == 7'b0,
          "R1", "reset state", {busy, done, writeOperand, writeAcc, flagUpdate, illegalOp, divError}, 0);

    issue(0, 0, 16'h005A, 16'h00A5, 32'h0);        // R3 zero result
    issue(0, 1, 16'h8001, 16'h8000, 32'h0);        // R3 sign set, word
    issue(1, 0, 16'h1234, 16'h0, 32'h0);           // R4
    issue(2, 0, 16'h1234, 16'h0, 32'h0);           // R5 byte keeps high
    issue(2, 1, 16'h0F0F, 16'h0, 32'h0);           // R5 word
    issue(3, 0, 16'hAB80, 16'h0, 32'h0);           // R6 most negative byte
    issue(3, 0, 16'h0000, 16'h0, 32'h0);           // R6 zero operand
    issue(3, 1, 16'h0001, 16'h0, 32'h0);           // R6 word
    issue(4, 0, 16'h00FF, 16'h0, 32'hABCD00FF);    // R7 high half significant
    issue(4, 1, 16'h0003, 16'h0, 32'h00000005);    // R7 word, fits
    issue(5, 0, 16'h0003, 16'h0, 32'h000000FE);    // R8 -2*3
    issue(5, 0, 16'h0080, 16'h0, 32'h00000080);    // R8 -128*-128
    issue(5, 1, 16'hFFFF, 16'h0, 32'h00001234);    // R8 word
    issue(6, 0, 16'h0010, 16'h0, 32'h55660107);    // R9 byte
    pokeWhileBusy();                                // R1 ignored while busy
    issue(6, 1, 16'h1000, 16'h0, 32'h00123456);    // R9 word
    issue(6, 0, 16'h0002, 16'h0, 32'h00001000);    // R11 quotient overflow
    issue(6, 1, 16'h0000, 16'h0, 32'h00000010);    // R11 zero divisor
    issue(7, 0, 16'h0002, 16'h0, 32'h0000FFF9);    // R10 -7/2
    issue(7, 1, 16'hFFFD, 16'h0, 32'h00000064);    // R10 100/-3 word
    issue(7, 0, 16'h00FF, 16'h0, 32'h0000FF80);    // R11 -128/-1
    pokeWhileBusy();                                // R1 ignored while busy
    issue(0, 0, 16'h0001, 16'h0001, 32'h0);        // R3 after poke
    while (expQ.size() != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);
    finished = 1;
    summary();
  end
endmodule